// File: doc/BRIEF.md
# Single-Wire Ratio-Coded Command Receiver

This block listens to one already-synchronised control line and takes two-byte commands from it. Each bit is decoded from how the time the line spends low compares with the time it spends high. Because only that ratio counts, one receiver accepts senders whose bit rates differ by a wide factor. The first byte must carry the fixed device address 0x72. The second byte carries an acknowledge request, a two-bit sub-address and a 5-bit brightness code. On a good frame the block latches the code and pulses a frame-valid strobe. When the sender asked for it, the block also drives an open-drain pull-down for a fixed number of cycles as an acknowledge.

Any frame that breaks a timing or framing rule is dropped. The block then pulses an error flag, leaves the stored code as it was, gives no acknowledge and waits for a fresh start condition. The stored code goes back to full scale only on reset. All durations are parameterised counts of the sampling clock.

Top module: `ratio_cmd_rx`

## Requirements
- R1: A bit spans one falling edge to the next falling edge. Call its low-sample count L and its high-sample count H. The bit is 1 when H >= RATIO*L and 0 when L >= RATIO*H, with RATIO = 2 by default; equality with the bound is accepted. Bits arrive most significant first, and the result does not depend on the absolute bit rate.
- R2: When a bit meets neither ratio bound, frame_err_o pulses in the cycle where its closing falling edge is sampled. The frame is then dropped: level_o does not change and no acknowledge follows.
- R3: When the first byte is not 0x72, frame_err_o pulses at the end of that byte's end-of-stream period, and the frame is dropped.
- R4: The second byte carries the request flag in bit 7, a sub-address in bits 6:5 and the code in bits 4:0. If the sub-address is 00, then in the cycle after EOS_MIN consecutive low samples following the closing falling edge, level_o takes the code and frame_ok_o pulses. A sub-address other than 00 gives frame_err_o at that point instead.
- R5: A frame starts only at a falling edge that follows at least START_MIN high samples. A line that is already high counts toward this. Shorter high pulses while idle are ignored. A start condition shorter than START_MIN before the data byte gives frame_err_o at its falling edge.
- R6: After each byte's closing falling edge the line must stay low for EOS_MIN samples. If it rises earlier, frame_err_o pulses in the cycle where the rise is sampled.
- R7: On a good frame with the request flag set, let F be the edge where the final falling edge is sampled. ack_pull_o is then high after edges F+ACK_DLY-1 through F+ACK_DLY+ACK_LEN-2, which is exactly ACK_LEN cycles.
- R8: On a good frame with the request flag clear, ack_pull_o stays low.
- R9: From a good frame's end-of-stream until the acknowledge ends, line activity produces no strobe, no error and no change to the acknowledge timing.
- R10: Reset sets level_o to 31 and clears ack_pull_o, frame_ok_o and frame_err_o. Only reset restores 31.
- R11: Inside a byte, a line held at one level for TOUT_CYC samples gives frame_err_o on the TOUT_CYC-th sample, and the frame is abandoned.
- R12: frame_ok_o and frame_err_o are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_i | input | 1 | Synchronised control line level |
| level_o | output | 5 | Stored brightness code |
| ack_pull_o | output | 1 | Open-drain pull-down enable for the acknowledge |
| frame_ok_o | output | 1 | One-cycle strobe for an accepted frame |
| frame_err_o | output | 1 | One-cycle strobe for a rejected frame |

## Verification
The embedded properties check four things on every cycle: the two strobes are exclusive single pulses, the stored code moves only together with the valid strobe, no strobe or error appears while the acknowledge is driven, and every acknowledge pulse is exactly ACK_LEN cycles long. Several behaviours can only be shown by the bench's frame scenarios, because they depend on what the sender did. These are the decoded bit values at both ratio boundaries and at several rates, rejection by address, sub-address, bad ratio, short start, short end-of-stream and stuck line, the placement of the acknowledge window relative to the final edge, its absence when no request was made, and its immunity to line toggles during the delay.

// File: rtl/rcr_pkg.sv
// Shared definitions for the ratio-coded command receiver.
// Assumes: one device address and one reset code for the whole chip.
package rcr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a start condition
        ST_BIT,    // measuring bits of a byte
        ST_EOS,    // end-of-stream low after a byte
        ST_GAP,    // waiting for the start condition before the data byte
        ST_ACKW,   // delay before the acknowledge
        ST_ACK     // driving the acknowledge pull-down
    } rx_state_e;

    typedef struct packed {
        logic       req;   // acknowledge requested
        logic [1:0] sub;   // sub-address, must be zero
        logic [4:0] code;  // brightness code
    } cmd_byte_t;

    localparam logic [7:0] DEV_ADDR    = 8'h72;
    localparam logic [4:0] LEVEL_RESET = 5'd31;

endpackage

// File: rtl/rcr_phase_meter.sv
// Measures the low and high sample counts of the current bit period.
// A falling edge opens a new period and counts its own sample as low.
// Counters saturate at CNT_MAX. clr_i restarts both counts and takes
// priority over an edge.
// Assumes: line_i is already synchronised to clk.
module rcr_phase_meter #(
    parameter int CNT_MAX = 65535,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_i,
    input  logic             clr_i,
    output logic             fall_o,
    output logic [CNT_W-1:0] lo_cnt_o,
    output logic [CNT_W-1:0] hi_cnt_o
);

    localparam logic [CNT_W-1:0] CAP = CNT_W'(CNT_MAX);

    logic line_q;

    // Previous line sample, used for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= 1'b0;
        else        line_q <= line_i;
    end

    assign fall_o = line_q & ~line_i;

    // Low and high sample counters of the current period.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            lo_cnt_o <= '0;
            hi_cnt_o <= '0;
        end else if (fall_o) begin
            lo_cnt_o <= CNT_W'(1);
            hi_cnt_o <= '0;
        end else if (line_i) begin
            if (hi_cnt_o != CAP) hi_cnt_o <= hi_cnt_o + CNT_W'(1);
        end else begin
            if (lo_cnt_o != CAP) lo_cnt_o <= lo_cnt_o + CNT_W'(1);
        end
    end

    // A sampled high level must be recorded in the following cycle.
    p_high_seen_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (line_i && !clr_i) |=> (hi_cnt_o != '0));

endmodule

// File: rtl/rcr_bit_judge.sv
// Decides a bit value from its low and high sample counts.
// 1 when high >= RATIO*low, 0 when low >= RATIO*high, otherwise bad.
// Assumes: RATIO >= 2, so both bounds cannot hold at once for
// non-zero counts.
module rcr_bit_judge #(
    parameter int CNT_W = 16,
    parameter int RATIO = 2
) (
    input  logic [CNT_W-1:0] lo_i,
    input  logic [CNT_W-1:0] hi_i,
    output logic             one_o,
    output logic             bad_o
);

    localparam int XW = CNT_W + $clog2(RATIO + 1);

    logic [XW-1:0] lo_x, hi_x, lo_k, hi_k;
    logic          zero;

    assign lo_x = XW'(lo_i);
    assign hi_x = XW'(hi_i);

    // Scaled counts: a shift for the default ratio, a multiply otherwise.
    generate
        if (RATIO == 2) begin : g_shift
            assign lo_k = lo_x << 1;
            assign hi_k = hi_x << 1;
        end else begin : g_mul
            assign lo_k = lo_x * XW'(RATIO);
            assign hi_k = hi_x * XW'(RATIO);
        end
    endgenerate

    assign one_o = (hi_x >= lo_k);
    assign zero  = (lo_x >= hi_k);
    assign bad_o = !(one_o || zero);

endmodule

// File: rtl/rcr_frame_ctrl.sv
// Frame sequencer: start detection, bit shifting, end-of-stream check,
// address and sub-address check, code storage and acknowledge timing.
// Assumes: ACK_DLY > EOS_MIN >= 2, START_MIN <= TOUT_CYC, and the
// counts from the phase meter describe the current bit period.
module rcr_frame_ctrl
    import rcr_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int START_MIN = 200,
    parameter int EOS_MIN   = 200,
    parameter int ACK_DLY   = 400,
    parameter int ACK_LEN   = 51200,
    parameter int TOUT_CYC  = 65535
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_i,
    input  logic             fall_i,
    input  logic [CNT_W-1:0] lo_cnt_i,
    input  logic [CNT_W-1:0] hi_cnt_i,
    input  logic             one_i,
    input  logic             bad_i,
    output logic             clr_o,
    output logic [4:0]       level_o,
    output logic             ack_o,
    output logic             ok_o,
    output logic             err_o
);

    localparam int T_W = $clog2(ACK_DLY + ACK_LEN + EOS_MIN + 1);

    rx_state_e    state_q, state_d;
    logic [2:0]   bit_q, bit_d;
    logic         byte_q, byte_d;
    logic [7:0]   sh_q, sh_d;
    logic [T_W-1:0] t_q, t_d;
    logic [4:0]   lvl_q, lvl_d;
    logic         ok_d, err_d, ok_q, err_q;
    logic         start_ok, lo_tout, hi_tout, eos_done;
    cmd_byte_t    cmd;

    assign cmd      = cmd_byte_t'(sh_q);
    assign start_ok = (int'(hi_cnt_i) >= START_MIN);
    assign lo_tout  = (int'(lo_cnt_i) + 1 >= TOUT_CYC);
    assign hi_tout  = (int'(hi_cnt_i) + 1 >= TOUT_CYC);
    assign eos_done = (int'(t_q) + 1 >= EOS_MIN);

    // Next-state and datapath decisions for one sampled cycle.
    always_comb begin
        state_d = state_q;
        bit_d   = bit_q;
        byte_d  = byte_q;
        sh_d    = sh_q;
        t_d     = t_q;
        lvl_d   = lvl_q;
        ok_d    = 1'b0;
        err_d   = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (fall_i && start_ok) begin
                    state_d = ST_BIT;
                    bit_d   = '0;
                    byte_d  = 1'b0;
                end
            end
            ST_BIT: begin
                if (fall_i) begin
                    if (bad_i) begin
                        err_d   = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        sh_d = {sh_q[6:0], one_i};
                        if (bit_q == 3'd7) begin
                            state_d = ST_EOS;
                            t_d     = T_W'(1);
                        end else begin
                            bit_d = bit_q + 3'd1;
                        end
                    end
                end else if (line_i ? hi_tout : lo_tout) begin
                    err_d   = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_EOS: begin
                if (line_i) begin
                    err_d   = 1'b1;
                    state_d = ST_IDLE;
                end else begin
                    t_d = t_q + T_W'(1);
                    if (eos_done) begin
                        if (!byte_q) begin
                            if (sh_q == DEV_ADDR) begin
                                state_d = ST_GAP;
                            end else begin
                                err_d   = 1'b1;
                                state_d = ST_IDLE;
                            end
                        end else if (cmd.sub != 2'b00) begin
                            err_d   = 1'b1;
                            state_d = ST_IDLE;
                        end else begin
                            ok_d    = 1'b1;
                            lvl_d   = cmd.code;
                            state_d = cmd.req ? ST_ACKW : ST_IDLE;
                        end
                    end
                end
            end
            ST_GAP: begin
                if (fall_i) begin
                    if (start_ok) begin
                        state_d = ST_BIT;
                        bit_d   = '0;
                        byte_d  = 1'b1;
                    end else begin
                        err_d   = 1'b1;
                        state_d = ST_IDLE;
                    end
                end else if (!line_i && lo_tout) begin
                    err_d   = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_ACKW: begin
                t_d = t_q + T_W'(1);
                if (int'(t_q) + 1 >= ACK_DLY) begin
                    state_d = ST_ACK;
                    t_d     = '0;
                end
            end
            ST_ACK: begin
                t_d = t_q + T_W'(1);
                if (int'(t_q) + 1 >= ACK_LEN) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Restart the phase counts when a fresh start condition is awaited.
    assign clr_o = (state_d != state_q) &&
                   ((state_d == ST_IDLE) || (state_d == ST_GAP));

    // State, counters, stored code and strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
            byte_q  <= 1'b0;
            sh_q    <= '0;
            t_q     <= '0;
            lvl_q   <= LEVEL_RESET;
            ok_q    <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            bit_q   <= bit_d;
            byte_q  <= byte_d;
            sh_q    <= sh_d;
            t_q     <= t_d;
            lvl_q   <= lvl_d;
            ok_q    <= ok_d;
            err_q   <= err_d;
        end
    end

    assign level_o = lvl_q;
    assign ack_o   = (state_q == ST_ACK);
    assign ok_o    = ok_q;
    assign err_o   = err_q;

    // Checker-only run length of the acknowledge pulse.
    int unsigned ack_run;
    always_ff @(posedge clk) begin
        if (!rst_n || !ack_o) ack_run <= 0;
        else                  ack_run <= ack_run + 1;
    end

    p_pulse_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(ok_o && err_o));

    p_ok_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ok_o |=> !ok_o);

    p_level_only_on_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level_o) |-> ok_o);

    p_ack_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> (!ok_o && !err_o));

    p_no_ack_after_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !ack_o);

    p_ack_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_o) |-> (ack_run == ACK_LEN));

endmodule

// File: rtl/ratio_cmd_rx.sv
// Top of the single-wire ratio-coded command receiver.
// Wires the phase meter, the bit judge and the frame sequencer.
// Assumes: line_i is synchronised; all timing parameters are counts of clk.
module ratio_cmd_rx #(
    parameter int START_MIN = 200,
    parameter int EOS_MIN   = 200,
    parameter int ACK_DLY   = 400,
    parameter int ACK_LEN   = 51200,
    parameter int TOUT_CYC  = 65535,
    parameter int RATIO     = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_i,
    output logic [4:0] level_o,
    output logic       ack_pull_o,
    output logic       frame_ok_o,
    output logic       frame_err_o
);

    localparam int CNT_W = $clog2(TOUT_CYC + 1);

    logic             fall, clr, one, bad;
    logic [CNT_W-1:0] lo_cnt, hi_cnt;

    rcr_phase_meter #(
        .CNT_MAX (TOUT_CYC),
        .CNT_W   (CNT_W)
    ) u_meter (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_i   (line_i),
        .clr_i    (clr),
        .fall_o   (fall),
        .lo_cnt_o (lo_cnt),
        .hi_cnt_o (hi_cnt)
    );

    rcr_bit_judge #(
        .CNT_W (CNT_W),
        .RATIO (RATIO)
    ) u_judge (
        .lo_i  (lo_cnt),
        .hi_i  (hi_cnt),
        .one_o (one),
        .bad_o (bad)
    );

    rcr_frame_ctrl #(
        .CNT_W     (CNT_W),
        .START_MIN (START_MIN),
        .EOS_MIN   (EOS_MIN),
        .ACK_DLY   (ACK_DLY),
        .ACK_LEN   (ACK_LEN),
        .TOUT_CYC  (TOUT_CYC)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_i   (line_i),
        .fall_i   (fall),
        .lo_cnt_i (lo_cnt),
        .hi_cnt_i (hi_cnt),
        .one_i    (one),
        .bad_i    (bad),
        .clr_o    (clr),
        .level_o  (level_o),
        .ack_o    (ack_pull_o),
        .ok_o     (frame_ok_o),
        .err_o    (frame_err_o)
    );

endmodule

// File: tb/ratio_cmd_rx_test.sv
// Bench: drives frames on an open-drain line model and compares every
// output on every clock with behaviourally predicted event cycles.
module ratio_cmd_rx_test;

    localparam int P_START = 4;
    localparam int P_EOS   = 4;
    localparam int P_DLY   = 12;
    localparam int P_LEN   = 16;
    localparam int P_TOUT  = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       drv = 1'b1;
    logic       line;
    logic [4:0] level;
    logic       ack, ok, err;

    always #5 clk = ~clk;

    assign line = drv & ~ack;

    ratio_cmd_rx #(
        .START_MIN (P_START),
        .EOS_MIN   (P_EOS),
        .ACK_DLY   (P_DLY),
        .ACK_LEN   (P_LEN),
        .TOUT_CYC  (P_TOUT),
        .RATIO     (2)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_i      (line),
        .level_o     (level),
        .ack_pull_o  (ack),
        .frame_ok_o  (ok),
        .frame_err_o (err)
    );

    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    bit    chk_en = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R10";
    int    ok_cyc = -1, err_cyc = -1, ack_lo = -1, ack_hi = -2;
    int    lvl_cyc = -1;
    int    lvl_new = 31;
    int    exp_level = 31;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d cycle=%0d", req, what, act, exp, cyc);
        end
    endtask

    // Reference comparison on every clock, away from the active edge.
    always @(negedge clk) begin
        if (chk_en) begin
            if (cyc == lvl_cyc) exp_level = lvl_new;
            check(cur_req, "frame_ok (R12)", int'(ok), int'(cyc == ok_cyc));
            check(cur_req, "frame_err (R12)", int'(err), int'(cyc == err_cyc));
            check(cur_req, "ack_pull", int'(ack), int'(cyc >= ack_lo && cyc <= ack_hi));
            check(cur_req, "level", int'(level), exp_level);
        end
    end

    task automatic hold(input logic v, input int n);
        drv = v;
        repeat (n) @(negedge clk);
    endtask

    // mode: 0 normal, 1 short end-of-stream after byte 0, 2 short start before byte 1
    task automatic frame(input logic [7:0] a, input logic [7:0] d, input int u,
                         input bit exact, input int bad_pos, input int mode, input bit noise);
        logic [15:0] w;
        logic        b;
        int          f, lo, hi;
        w = {a, d};
        hold(1'b1, P_START + 2);
        for (int k = 0; k < 16; k++) begin
            if (k == 8) begin
                if (mode == 1) begin
                    hold(1'b0, P_EOS - 2);
                    err_cyc = cyc + 1;
                    hold(1'b1, 2);
                    hold(1'b0, 2);
                    return;
                end
                f = cyc + 1;
                if (a != 8'h72) err_cyc = f + P_EOS - 1;
                hold(1'b0, P_EOS);
                if (a != 8'h72) return;
                if (mode == 2) begin
                    hold(1'b1, P_START - 1);
                    err_cyc = cyc + 1;
                    hold(1'b0, 2);
                    return;
                end
                hold(1'b1, P_START);
            end
            if (k == bad_pos) begin
                hold(1'b0, 2 * u);
                hold(1'b1, 2 * u);
                err_cyc = cyc + 1;
                hold(1'b0, 2);
                return;
            end
            b  = w[15 - k];
            lo = b ? u : (exact ? 2 * u : 3 * u);
            hi = b ? (exact ? 2 * u : 3 * u) : u;
            hold(1'b0, lo);
            hold(1'b1, hi);
        end
        f = cyc + 1;
        if (d[6:5] != 2'b00) begin
            err_cyc = f + P_EOS - 1;
            hold(1'b0, P_EOS + 1);
        end else begin
            ok_cyc  = f + P_EOS - 1;
            lvl_cyc = ok_cyc;
            lvl_new = int'(d[4:0]);
            if (d[7]) begin
                ack_lo = f + P_DLY - 1;
                ack_hi = f + P_DLY + P_LEN - 2;
                if (noise) begin
                    hold(1'b0, P_EOS + 1);
                    hold(1'b1, 2);
                    hold(1'b0, P_DLY + P_LEN - P_EOS - 1);
                end else begin
                    hold(1'b0, P_DLY + P_LEN + 2);
                end
            end else begin
                hold(1'b0, P_EOS + 1);
            end
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        chk_en = 1'b1;
        @(negedge clk);
        // R10: reset state
        check("R10", "level after reset", int'(level), 31);
        check("R10", "ack after reset", int'(ack), 0);
        check("R10", "strobes after reset", int'(ok | err), 0);

        cur_req = "R1";
        frame(8'h72, 8'h0A, 2, 1'b0, -1, 0, 1'b0);
        check("R1", "code at rate u=2", int'(level), 10);
        frame(8'h72, 8'h13, 2, 1'b1, -1, 0, 1'b0);
        check("R1", "code at exact 2:1 bounds", int'(level), 19);
        frame(8'h72, 8'h05, 5, 1'b0, -1, 0, 1'b0);
        check("R1", "code at rate u=5", int'(level), 5);

        cur_req = "R7";
        frame(8'h72, 8'h87, 3, 1'b0, -1, 0, 1'b0);
        check("R7", "code with acknowledge", int'(level), 7);

        cur_req = "R9";
        frame(8'h72, 8'h9C, 2, 1'b0, -1, 0, 1'b1);
        check("R9", "code after line noise in delay", int'(level), 28);

        cur_req = "R8";
        frame(8'h72, 8'h1E, 2, 1'b0, -1, 0, 1'b0);
        check("R8", "code without request", int'(level), 30);

        cur_req = "R2";
        frame(8'h72, 8'h01, 2, 1'b0, 3, 0, 1'b0);
        check("R2", "code kept after bad address bit", int'(level), 30);
        frame(8'h72, 8'h8F, 2, 1'b0, 12, 0, 1'b0);
        check("R2", "code kept after bad data bit", int'(level), 30);

        cur_req = "R3";
        frame(8'h73, 8'h02, 2, 1'b0, -1, 0, 1'b0);
        check("R3", "code kept after wrong address", int'(level), 30);

        cur_req = "R4";
        frame(8'h72, 8'hA4, 2, 1'b0, -1, 0, 1'b0);
        check("R4", "code kept after nonzero sub-address", int'(level), 30);

        cur_req = "R6";
        frame(8'h72, 8'h03, 2, 1'b0, -1, 1, 1'b0);
        check("R6", "code kept after short end-of-stream", int'(level), 30);

        cur_req = "R5";
        frame(8'h72, 8'h04, 2, 1'b0, -1, 2, 1'b0);
        check("R5", "code kept after short start", int'(level), 30);
        for (int i = 0; i < 3; i++) begin
            hold(1'b1, P_START - 1);
            hold(1'b0, 3);
        end
        check("R5", "no strobe after short idle pulses", int'(ok | err), 0);
        frame(8'h72, 8'h0C, 2, 1'b0, -1, 0, 1'b0);
        check("R5", "code after short idle pulses", int'(level), 12);

        cur_req = "R11";
        hold(1'b1, P_START + 2);
        hold(1'b0, 2);
        err_cyc = cyc + P_TOUT;
        hold(1'b1, P_TOUT);
        hold(1'b0, 3);
        check("R11", "code kept after stuck-high line", int'(level), 12);

        cur_req = "R4";
        frame(8'h72, 8'h00, 4, 1'b0, -1, 0, 1'b0);
        check("R4", "code zero stored", int'(level), 0);

        hold(1'b1, 10);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule